// File: doc/BRIEF.md
# Inter-Processor Word FIFO Pair

Two processors exchange 32-bit words through this block. Each side owns a send queue that only it can fill and only the other side can drain. Each side has three access points: a 16-bit control/status register, a send-data write strobe and a receive-data read strobe. Each side also has two interrupt request outputs. One fires when that side's send queue has drained. The other fires when that side's receive queue holds data.

Interrupts come from two sources. Cross events come from the peer: a word pushed toward a side, or the last word popped from a side's send queue. Local events come from a side's own control write, when an interrupt enable goes from 0 to 1 and the condition it watches is already true. Either side can drop its transfers by clearing its enable. While disabled, a side's accesses move no data, and a receive read returns the current head without popping it. Misuse sets a sticky error flag: pushing into a full queue, or popping an empty one while enabled.

Top module: `xfifo_pair`

## Requirements
- R1: After reset, both control reads return 0x0101 (both queues empty, every stored bit 0). Both receive data outputs read 0 and all interrupt outputs are low.
- R2: A control write stores only bit 15 (enable), bit 10 (receive-not-empty interrupt enable) and bit 2 (send-empty interrupt enable). Every other written bit is dropped, apart from the actions of bits 3 and 14. The stored bits read back at the same positions one cycle later.
- R3: The control read shows own send queue empty at bit 0 and full at bit 1, with bit 1 shown only when bit 0 is clear. It shows receive queue empty at bit 8 and full at bit 9, with bit 9 shown only when bit 8 is clear.
- R4: A send write while enabled and not full pushes the word. If the peer's bit 10 is set, the peer's receive interrupt pulses one cycle later, whatever the peer's enable.
- R5: A send write while enabled into a full queue drops the word and sets the error flag (bit 14).
- R6: While a side is disabled (bit 15 = 0), its send writes are ignored, it raises no error, and its receive reads return the head in the same cycle without popping.
- R7: A receive read while enabled on a non-empty queue returns the head in the same cycle and pops it. If that pop empties the queue and the peer's bit 2 is set, the peer's send-empty interrupt pulses one cycle later.
- R8: A receive read while enabled on an empty queue sets the error flag and returns the last held head. That is the last word popped, or the head at the last flush, or 0 after reset.
- R9: The error flag stays set until a control write with bit 14 = 1 clears it. If a new error occurs in the same cycle as the clear, the error stays set.
- R10: A control write with bit 3 = 1 empties that side's send queue. A send write in the same cycle is dropped and raises no peer interrupt.
- R11: A control write that raises bit 2 from 0 to 1 pulses the same side's send-empty interrupt one cycle later if the own send queue is empty, or is being flushed by that write.
- R12: A control write that raises bit 10 from 0 to 1 pulses the same side's receive interrupt one cycle later if the receive queue is not empty.
- R13: Interrupt outputs are registered single-cycle pulses: high one cycle after their event and low again the cycle after, unless a new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ctl_we_i | input | 1 | Side A control write strobe |
| a_ctl_wdata_i | input | 16 | Side A control write value |
| a_ctl_rdata_o | output | 16 | Side A control/status read value |
| a_tx_we_i | input | 1 | Side A send-data write strobe |
| a_tx_wdata_i | input | 32 | Side A send word |
| a_rx_re_i | input | 1 | Side A receive-data read strobe |
| a_rx_rdata_o | output | 32 | Side A receive head word |
| a_irq_txe_o | output | 1 | Side A send-empty interrupt pulse |
| a_irq_rxne_o | output | 1 | Side A receive-not-empty interrupt pulse |
| b_ctl_we_i | input | 1 | Side B control write strobe |
| b_ctl_wdata_i | input | 16 | Side B control write value |
| b_ctl_rdata_o | output | 16 | Side B control/status read value |
| b_tx_we_i | input | 1 | Side B send-data write strobe |
| b_tx_wdata_i | input | 32 | Side B send word |
| b_rx_re_i | input | 1 | Side B receive-data read strobe |
| b_rx_rdata_o | output | 32 | Side B receive head word |
| b_irq_txe_o | output | 1 | Side B send-empty interrupt pulse |
| b_irq_rxne_o | output | 1 | Side B receive-not-empty interrupt pulse |

## Verification
Receive data is combinational, so it is due in the cycle of the read strobe. Status bits and the error flag change at the clock edge that ends the strobe cycle, so they are due one cycle later. Interrupt pulses are also due one cycle after their event and must be low again two cycles after it. Each expected item is queued with the cycle it is due, counted from the cycle in which the stimulus was held. The monitor compares an item only in that cycle, at the falling clock edge, while inputs change only just after rising edges.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  localparam int unsigned CTL_W      = 16;
  // control/status bit positions
  localparam int unsigned B_TX_EMPTY = 0;
  localparam int unsigned B_TX_FULL  = 1;
  localparam int unsigned B_TXE_IE   = 2;
  localparam int unsigned B_FLUSH    = 3;
  localparam int unsigned B_RX_EMPTY = 8;
  localparam int unsigned B_RX_FULL  = 9;
  localparam int unsigned B_RXNE_IE  = 10;
  localparam int unsigned B_ERR      = 14;
  localparam int unsigned B_EN       = 15;

  typedef struct packed {
    logic en;
    logic rxne_ie;
    logic txe_ie;
  } side_cfg_t;
endpackage

// File: rtl/xfp_fifo.sv
module xfp_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              last_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] held_q;
  logic              do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign last_o  = (cnt_q == CW'(1));
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign head_o  = empty_o ? held_q : mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      held_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      if (!empty_o) held_q <= mem_q[rp_q];
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop) begin
        rp_q   <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
        held_q <= mem_q[rp_q];
      end
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/xfp_side.sv
module xfp_side
  import xfp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             tx_we_i,
  input  logic             rx_re_i,
  input  logic             tx_empty_i,
  input  logic             tx_full_i,
  input  logic             rx_empty_i,
  input  logic             rx_full_i,
  input  logic             peer_push_ok_i,
  input  logic             peer_pop_last_i,
  output logic             flush_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [CTL_W-1:0] ctl_rdata_o,
  output logic             irq_txe_o,
  output logic             irq_rxne_o
);
  side_cfg_t cfg_q;
  logic      err_q;
  logic      err_set, err_clr, txe_rise, rxne_rise, txe_d, rxne_d;
  logic      unused_wbits;

  assign unused_wbits = ^{ctl_wdata_i[13:11], ctl_wdata_i[9:4], ctl_wdata_i[1:0]};

  assign flush_o = ctl_we_i & ctl_wdata_i[B_FLUSH];
  assign push_o  = tx_we_i & cfg_q.en;
  assign pop_o   = rx_re_i & cfg_q.en & ~rx_empty_i;

  assign err_set = cfg_q.en & ((tx_we_i & tx_full_i) | (rx_re_i & rx_empty_i));
  assign err_clr = ctl_we_i & ctl_wdata_i[B_ERR];

  assign txe_rise  = ctl_we_i & ctl_wdata_i[B_TXE_IE]  & ~cfg_q.txe_ie;
  assign rxne_rise = ctl_we_i & ctl_wdata_i[B_RXNE_IE] & ~cfg_q.rxne_ie;
  // flush in the same write counts as empty
  assign txe_d  = (txe_rise & (tx_empty_i | flush_o)) | (peer_pop_last_i & cfg_q.txe_ie);
  assign rxne_d = (rxne_rise & ~rx_empty_i) | (peer_push_ok_i & cfg_q.rxne_ie);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      err_q      <= 1'b0;
      irq_txe_o  <= 1'b0;
      irq_rxne_o <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        cfg_q.en      <= ctl_wdata_i[B_EN];
        cfg_q.rxne_ie <= ctl_wdata_i[B_RXNE_IE];
        cfg_q.txe_ie  <= ctl_wdata_i[B_TXE_IE];
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      irq_txe_o  <= txe_d;
      irq_rxne_o <= rxne_d;
    end
  end

  always_comb begin
    ctl_rdata_o             = '0;
    ctl_rdata_o[B_EN]       = cfg_q.en;
    ctl_rdata_o[B_ERR]      = err_q;
    ctl_rdata_o[B_RXNE_IE]  = cfg_q.rxne_ie;
    ctl_rdata_o[B_RX_FULL]  = rx_full_i & ~rx_empty_i;
    ctl_rdata_o[B_RX_EMPTY] = rx_empty_i;
    ctl_rdata_o[B_TXE_IE]   = cfg_q.txe_ie;
    ctl_rdata_o[B_TX_FULL]  = tx_full_i & ~tx_empty_i;
    ctl_rdata_o[B_TX_EMPTY] = tx_empty_i;
  end
endmodule

// File: rtl/xfifo_pair.sv
module xfifo_pair
  import xfp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_ctl_we_i,
  input  logic [CTL_W-1:0]  a_ctl_wdata_i,
  output logic [CTL_W-1:0]  a_ctl_rdata_o,
  input  logic              a_tx_we_i,
  input  logic [DATA_W-1:0] a_tx_wdata_i,
  input  logic              a_rx_re_i,
  output logic [DATA_W-1:0] a_rx_rdata_o,
  output logic              a_irq_txe_o,
  output logic              a_irq_rxne_o,
  input  logic              b_ctl_we_i,
  input  logic [CTL_W-1:0]  b_ctl_wdata_i,
  output logic [CTL_W-1:0]  b_ctl_rdata_o,
  input  logic              b_tx_we_i,
  input  logic [DATA_W-1:0] b_tx_wdata_i,
  input  logic              b_rx_re_i,
  output logic [DATA_W-1:0] b_rx_rdata_o,
  output logic              b_irq_txe_o,
  output logic              b_irq_rxne_o
);
  localparam int unsigned NSIDE = 2;

  logic [NSIDE-1:0]  ctl_we, tx_we, rx_re;
  logic [NSIDE-1:0]  flush, push, pop, empty, full, last;
  logic [NSIDE-1:0]  push_ok, pop_last, irq_txe, irq_rxne;
  logic [CTL_W-1:0]  ctl_wdata [NSIDE];
  logic [CTL_W-1:0]  ctl_rdata [NSIDE];
  logic [DATA_W-1:0] tx_wdata  [NSIDE];
  logic [DATA_W-1:0] head      [NSIDE];

  assign ctl_we       = {b_ctl_we_i, a_ctl_we_i};
  assign tx_we        = {b_tx_we_i, a_tx_we_i};
  assign rx_re        = {b_rx_re_i, a_rx_re_i};
  assign ctl_wdata[0] = a_ctl_wdata_i;
  assign ctl_wdata[1] = b_ctl_wdata_i;
  assign tx_wdata[0]  = a_tx_wdata_i;
  assign tx_wdata[1]  = b_tx_wdata_i;

  // queue s is side s's send queue, drained by side 1-s
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int P = 1 - s;

    xfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush[s]),
      .push_i  (push[s]),
      .wdata_i (tx_wdata[s]),
      .pop_i   (pop[P]),
      .head_o  (head[s]),
      .empty_o (empty[s]),
      .full_o  (full[s]),
      .last_o  (last[s])
    );

    assign push_ok[s]  = push[s] & ~full[s] & ~flush[s];
    assign pop_last[s] = pop[P] & last[s] & ~flush[s];

    xfp_side u_side (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .ctl_we_i        (ctl_we[s]),
      .ctl_wdata_i     (ctl_wdata[s]),
      .tx_we_i         (tx_we[s]),
      .rx_re_i         (rx_re[s]),
      .tx_empty_i      (empty[s]),
      .tx_full_i       (full[s]),
      .rx_empty_i      (empty[P]),
      .rx_full_i       (full[P]),
      .peer_push_ok_i  (push_ok[P]),
      .peer_pop_last_i (pop_last[s]),
      .flush_o         (flush[s]),
      .push_o          (push[s]),
      .pop_o           (pop[s]),
      .ctl_rdata_o     (ctl_rdata[s]),
      .irq_txe_o       (irq_txe[s]),
      .irq_rxne_o      (irq_rxne[s])
    );
  end

  assign a_ctl_rdata_o = ctl_rdata[0];
  assign b_ctl_rdata_o = ctl_rdata[1];
  assign a_rx_rdata_o  = head[1];
  assign b_rx_rdata_o  = head[0];
  assign a_irq_txe_o   = irq_txe[0];
  assign a_irq_rxne_o  = irq_rxne[0];
  assign b_irq_txe_o   = irq_txe[1];
  assign b_irq_rxne_o  = irq_rxne[1];
endmodule

// File: rtl/xfifo_pair_chk.sv
module xfifo_pair_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_ctl_we_i,
  input logic              a_wr_flush_i,
  input logic              a_wr_errclr_i,
  input logic              a_tx_we_i,
  input logic              a_rx_re_i,
  input logic              a_en_i,
  input logic              a_err_i,
  input logic              a_txfull_i,
  input logic              a_txempty_i,
  input logic              a_rxempty_i,
  input logic              b_en_i,
  input logic              b_rxne_ie_i,
  input logic              b_txempty_i,
  input logic              b_rx_re_i,
  input logic [DATA_W-1:0] b_rx_rdata_i,
  input logic              b_irq_rxne_i
);
  // R3
  rx_tx_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rxempty_i == b_txempty_i);

  // R4
  peer_rxne_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_tx_we_i && !a_txfull_i && !(a_ctl_we_i && a_wr_flush_i) && b_rxne_ie_i)
    |=> b_irq_rxne_i);

  // R5
  full_push_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_tx_we_i && a_txfull_i) |=> a_err_i);

  // R6
  dis_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_en_i && b_rx_re_i && !a_tx_we_i && !a_ctl_we_i) |=> $stable(b_rx_rdata_i));

  // R8
  empty_pop_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_rx_re_i && a_rxempty_i) |=> a_err_i);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_err_i && !(a_ctl_we_i && a_wr_errclr_i)) |=> a_err_i);

  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ctl_we_i && a_wr_flush_i) |=> a_txempty_i);
endmodule

bind xfifo_pair xfifo_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .a_ctl_we_i    (a_ctl_we_i),
  .a_wr_flush_i  (a_ctl_wdata_i[3]),
  .a_wr_errclr_i (a_ctl_wdata_i[14]),
  .a_tx_we_i     (a_tx_we_i),
  .a_rx_re_i     (a_rx_re_i),
  .a_en_i        (a_ctl_rdata_o[15]),
  .a_err_i       (a_ctl_rdata_o[14]),
  .a_txfull_i    (a_ctl_rdata_o[1]),
  .a_txempty_i   (a_ctl_rdata_o[0]),
  .a_rxempty_i   (a_ctl_rdata_o[8]),
  .b_en_i        (b_ctl_rdata_o[15]),
  .b_rxne_ie_i   (b_ctl_rdata_o[10]),
  .b_txempty_i   (b_ctl_rdata_o[0]),
  .b_rx_re_i     (b_rx_re_i),
  .b_rx_rdata_i  (b_rx_rdata_o),
  .b_irq_rxne_i  (b_irq_rxne_o)
);

// File: tb/sim_xfifo_pair.sv
`timescale 1ns/1ps
module sim_xfifo_pair;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_ctl_we = 0, b_ctl_we = 0, a_tx_we = 0, b_tx_we = 0, a_rx_re = 0, b_rx_re = 0;
  logic [15:0] a_ctl_wdata = '0, b_ctl_wdata = '0, a_ctl_rdata, b_ctl_rdata;
  logic [31:0] a_tx_wdata = '0, b_tx_wdata = '0, a_rx_rdata, b_rx_rdata;
  logic        a_irq_txe, a_irq_rxne, b_irq_txe, b_irq_rxne;

  always #2.5 clk = ~clk;

  xfifo_pair u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_ctl_we_i(a_ctl_we), .a_ctl_wdata_i(a_ctl_wdata), .a_ctl_rdata_o(a_ctl_rdata),
    .a_tx_we_i(a_tx_we), .a_tx_wdata_i(a_tx_wdata), .a_rx_re_i(a_rx_re), .a_rx_rdata_o(a_rx_rdata),
    .a_irq_txe_o(a_irq_txe), .a_irq_rxne_o(a_irq_rxne),
    .b_ctl_we_i(b_ctl_we), .b_ctl_wdata_i(b_ctl_wdata), .b_ctl_rdata_o(b_ctl_rdata),
    .b_tx_we_i(b_tx_we), .b_tx_wdata_i(b_tx_wdata), .b_rx_re_i(b_rx_re), .b_rx_rdata_o(b_rx_rdata),
    .b_irq_txe_o(b_irq_txe), .b_irq_rxne_o(b_irq_rxne)
  );

  // signal ids: 0 a_ctl 1 b_ctl 2 a_rx 3 b_rx 4 a_txe 5 a_rxne 6 b_txe 7 b_rxne
  typedef struct {
    int unsigned due;
    int          id;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int unsigned cyc = 0;
  int          total = 0, bad = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int id);
    case (id)
      0: return {16'h0, a_ctl_rdata};
      1: return {16'h0, b_ctl_rdata};
      2: return a_rx_rdata;
      3: return b_rx_rdata;
      4: return {31'h0, a_irq_txe};
      5: return {31'h0, a_irq_rxne};
      6: return {31'h0, b_irq_txe};
      default: return {31'h0, b_irq_rxne};
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        logic [31:0] act;
        act = observe(sbq[i].id);
        total++;
        if (act !== sbq[i].val) begin
          bad++;
          $display("FAIL %s sig%0d cyc=%0d actual=%h expected=%h",
                   sbq[i].tag, sbq[i].id, cyc, act, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic want(int id, logic [31:0] v, int d, string tag);
    sbq.push_back('{cyc + d, id, v, tag});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    a_ctl_we = 0; b_ctl_we = 0; a_tx_we = 0; b_tx_we = 0; a_rx_re = 0; b_rx_re = 0;
  endtask

  task automatic ctl_wr(int s, logic [15:0] v);
    if (s == 0) begin a_ctl_we = 1; a_ctl_wdata = v; end
    else        begin b_ctl_we = 1; b_ctl_wdata = v; end
  endtask

  task automatic tx_wr(int s, logic [31:0] v);
    if (s == 0) begin a_tx_we = 1; a_tx_wdata = v; end
    else        begin b_tx_we = 1; b_tx_wdata = v; end
  endtask

  task automatic rx_rd(int s);
    if (s == 0) a_rx_re = 1;
    else        b_rx_re = 1;
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    want(0, 32'h0101, 0, "R1"); want(1, 32'h0101, 0, "R1");
    want(2, 0, 0, "R1"); want(3, 0, 0, "R1");
    want(4, 0, 0, "R1"); want(7, 0, 0, "R1");
    step();
    // R2 junk bits dropped; R11 local send-empty on rise
    ctl_wr(0, 16'h84F4);
    want(0, 32'h8505, 1, "R2"); want(4, 1, 1, "R11"); want(4, 0, 2, "R13"); want(5, 0, 1, "R12");
    step();
    ctl_wr(1, 16'h8000); want(1, 32'h8101, 1, "R2"); step();
    // R3 / R4 push, peer bit10 clear
    tx_wr(0, 32'h11111111);
    want(0, 32'h8504, 1, "R3"); want(1, 32'h8001, 1, "R3"); want(7, 0, 1, "R4");
    step();
    // R12 rising bit10 with data waiting
    ctl_wr(1, 16'h8400); want(7, 1, 1, "R12"); want(1, 32'h8401, 1, "R2"); step();
    tx_wr(0, 32'h22222222); want(7, 1, 1, "R4"); want(7, 0, 2, "R13"); step();
    // R7 pops
    rx_rd(1); want(3, 32'h11111111, 0, "R7"); step();
    rx_rd(1); want(3, 32'h22222222, 0, "R7"); want(4, 1, 1, "R7"); want(0, 32'h8505, 1, "R7"); step();
    // R8 empty read
    rx_rd(1); want(3, 32'h22222222, 0, "R8"); want(1, 32'hC501, 1, "R8"); step();
    // R9 sticky then cleared
    want(1, 32'hC501, 0, "R9"); step();
    ctl_wr(1, 16'hC400); want(1, 32'h8501, 1, "R9"); want(7, 0, 1, "R12"); step();
    // fill to full
    for (int i = 0; i < 16; i++) begin
      tx_wr(0, 32'h100 + i);
      step();
    end
    want(0, 32'h8506, 0, "R3"); want(1, 32'h8601, 0, "R3"); want(7, 1, 0, "R4");
    // R5 push into full
    tx_wr(0, 32'hDEAD); want(0, 32'hC506, 1, "R5"); want(7, 0, 1, "R5"); step();
    rx_rd(1); want(3, 32'h100, 0, "R7"); step();
    // R6 disabled side
    ctl_wr(1, 16'h0400); want(1, 32'h0401, 1, "R6"); step();
    rx_rd(1); want(3, 32'h101, 0, "R6"); step();
    rx_rd(1); want(3, 32'h101, 0, "R6"); want(1, 32'h0401, 1, "R6"); step();
    tx_wr(1, 32'h5555);
    want(1, 32'h0401, 1, "R6"); want(0, 32'hC504, 1, "R6"); want(5, 0, 1, "R6");
    step();
    // R10 flush with error clear
    ctl_wr(0, 16'hC40C);
    want(0, 32'h8505, 1, "R10"); want(1, 32'h0501, 1, "R10"); want(3, 32'h101, 1, "R10"); want(4, 0, 1, "R11");
    step();
    // R11 rise needs empty queue; flush in the same write counts
    ctl_wr(0, 16'h8400); step();
    tx_wr(0, 32'h77); want(7, 1, 1, "R4"); step();
    ctl_wr(0, 16'h8404); want(4, 0, 1, "R11"); step();
    ctl_wr(0, 16'h8400); step();
    ctl_wr(0, 16'h840C); want(4, 1, 1, "R11"); want(0, 32'h8505, 1, "R10"); want(3, 32'h77, 1, "R10"); step();
    // R10 push dropped during flush
    ctl_wr(0, 16'h8408); tx_wr(0, 32'h88); want(0, 32'h8501, 1, "R10"); want(7, 0, 1, "R10"); step();
    // side A receive path
    ctl_wr(1, 16'h8000); step();
    ctl_wr(0, 16'h8004); step();
    tx_wr(1, 32'h99); want(5, 0, 1, "R4"); step();
    ctl_wr(0, 16'h8404); want(5, 1, 1, "R12"); step();
    rx_rd(0); want(2, 32'h99, 0, "R7"); want(6, 0, 1, "R7"); step();
    rx_rd(0); want(2, 32'h99, 0, "R8"); want(0, 32'hC505, 1, "R8"); step();
    repeat (4) step();
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R13 pending actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule